// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Timing Controller

This block sits between a synchronous host and an asynchronous static RAM with a byte-wide data path. The host offers one single-byte read or write at a time through a valid/ready handshake. The controller then runs the memory strobes (RAM chip enable, write enable and output enable) and the address and write-data lines, holding every phase for a whole number of clock cycles. It signals completion with a one-cycle response pulse that carries the read data.

Phase lengths are derived at elaboration time from nanosecond timing parameters and a clock-period parameter. Each figure is rounded up to whole cycles, with a floor of one cycle. A read keeps the RAM selected with its outputs enabled until the slowest of the read-cycle, address-access and output-enable-access limits has passed. A write lowers chip enable and write enable together. It keeps the data bus undriven until the memory is known to have released it, drives the write data long enough to meet the setup limit, and then raises both strobes on one edge. If the write pulse is shorter than the minimum write cycle, the controller adds an idle tail with the address held. The memory side uses separate data-out, data-in and drive-enable signals. A second enable output, for a companion one-time-programmable array that shares the bus, is held inactive permanently.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `reqReady` is 1, `respValid` is 0, `ramCeN`, `memWeN`, `memOeN` and `otpCeN` are 1, and `memDriveEn` is 0.
- R2: An accepted read (`reqWrite`=0) keeps `ramCeN`=0 and `memOeN`=0 with `memWeN`=1 for exactly RD cycles, where RD is the largest of ceil(T_READ_CYCLE_NS/CLK_PERIOD_NS), ceil(T_ADDR_ACCESS_NS/CLK_PERIOD_NS) and ceil(T_OE_ACCESS_NS/CLK_PERIOD_NS), each at least 1. `memAddr` equals the request address throughout. Write enable and output enable are never low together.
- R3: The byte on `memDin` in the last of the RD cycles is returned on `respRdata` in the response cycle.
- R4: An accepted write (`reqWrite`=1) keeps `ramCeN`=0 and `memWeN`=0 with `memOeN`=1 for exactly WP cycles. WP is the largest of ceil(T_WRITE_PULSE_NS/P), ceil(T_ADDR_VALID_END_NS/P) and ceil(T_WE_FLOAT_NS/P)+ceil(T_DATA_SETUP_NS/P), each term at least 1. Both strobes rise in the same cycle.
- R5: During a write pulse, `memDriveEn` stays 0 for the first ceil(T_WE_FLOAT_NS/P) cycles (minimum 1) after `memWeN` falls. It is then 1 until `memWeN` rises, and only while `memWeN` is 0. `memDout` carries the request data, so the byte committed at the end of the write is the host's byte at the host's address.
- R6: When ceil(T_WRITE_CYCLE_NS/P) exceeds WP, a write is followed by that many minus WP cycles with all strobes high and the address held, before the response.
- R7: `respValid` is 1 for exactly one cycle directly after each operation's last memory cycle. `reqReady` is 0 from the cycle after acceptance through the response cycle. `reqValid` held high while `reqReady` is 0 starts no operation and writes nothing.
- R8: `otpCeN` is 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Host request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | DATA_W | Write byte |
| reqReady | output | 1 | Controller idle, request accepted this cycle if valid |
| respValid | output | 1 | One-cycle completion pulse |
| respRdata | output | DATA_W | Last byte read |
| memAddr | output | ADDR_W | Memory address lines |
| memDout | output | DATA_W | Data toward the memory |
| memDin | input | DATA_W | Data from the memory |
| memDriveEn | output | 1 | Enables the data-out drivers onto the bus |
| ramCeN | output | 1 | RAM chip enable, active low |
| otpCeN | output | 1 | Companion array enable, active low, held high |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low |

## Verification
The bench builds the block with its defaults: a 10 ns period, 100 ns read and write cycles, 100 ns address access, 50 ns output-enable access, a 75 ns write pulse, 90 ns address-to-end, 40 ns data setup and 35 ns bus release. These values give a 10-cycle read and a 9-cycle write pulse. In that pulse the address-to-end limit, not the pulse-width or float-plus-setup sums, sets the length. The 35 ns release rounds up to 4 cycles, and a one-cycle tail is needed to reach the write cycle, so the rounding, the largest-term choice and the tail path are all exercised. A held request during busy cycles and back-to-back operations at the extreme addresses probe the handshake.

// File: rtl/sramctl_pkg.sv
package sramctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WPULSE,
    ST_WTAIL,
    ST_DONE
  } ctlState_t;

  typedef struct packed {
    logic load;
    logic ceOn;
    logic weOn;
    logic oeOn;
    logic driveOn;
    logic capture;
    logic done;
  } strobe_t;

  function automatic int ceilCycles(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cycle_ctrl_fsm.sv
module sram_cycle_ctrl_fsm
  import sramctl_pkg::*;
#(
  parameter int RD_CYC    = 10,
  parameter int PULSE_CYC = 9,
  parameter int FLOAT_CYC = 4,
  parameter int TAIL_CYC  = 1,
  parameter int CNT_W     = 4
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t strobe
);

  localparam int TAIL_LAST_I = (TAIL_CYC > 0) ? TAIL_CYC - 1 : 0;
  localparam logic [CNT_W-1:0] RD_LAST    = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] TAIL_LAST  = CNT_W'(TAIL_LAST_I);
  localparam logic [CNT_W-1:0] FLOAT_END  = CNT_W'(FLOAT_CYC);

  ctlState_t state;
  ctlState_t afterPulse;
  logic [CNT_W-1:0] cnt;

  generate
    if (TAIL_CYC > 0) begin : g_tail
      assign afterPulse = ST_WTAIL;
    end else begin : g_noTail
      assign afterPulse = ST_DONE;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (reqValid) state <= reqWrite ? ST_WPULSE : ST_READ;
        end
        ST_READ: begin
          if (cnt == RD_LAST) begin
            state <= ST_DONE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WPULSE: begin
          if (cnt == PULSE_LAST) begin
            state <= afterPulse;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WTAIL: begin
          if (cnt == TAIL_LAST) begin
            state <= ST_DONE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  always_comb begin
    reqReady        = (state == ST_IDLE);
    strobe          = '0;
    strobe.load     = reqReady && reqValid;
    strobe.ceOn     = (state == ST_READ) || (state == ST_WPULSE);
    strobe.oeOn     = (state == ST_READ);
    strobe.weOn     = (state == ST_WPULSE);
    strobe.driveOn  = (state == ST_WPULSE) && (cnt >= FLOAT_END);
    strobe.capture  = (state == ST_READ) && (cnt == RD_LAST);
    strobe.done     = (state == ST_DONE);
  end

endmodule

// File: rtl/sram_cycle_ctrl_dp.sv
module sram_cycle_ctrl_dp
  import sramctl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic              respValid,
  output logic [DATA_W-1:0] respRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDriveEn,
  output logic              ramCeN,
  output logic              otpCeN,
  output logic              memWeN,
  output logic              memOeN
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (strobe.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strobe.capture) rdataQ <= memDin;
    end
  end

  assign memAddr    = addrQ;
  assign memDout    = wdataQ;
  assign memDriveEn = strobe.driveOn;
  assign ramCeN     = ~strobe.ceOn;
  assign memWeN     = ~strobe.weOn;
  assign memOeN     = ~strobe.oeOn;
  assign otpCeN     = 1'b1;
  assign respValid  = strobe.done;
  assign respRdata  = rdataQ;

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sramctl_pkg::*;
#(
  parameter int ADDR_W              = 17,
  parameter int DATA_W              = 8,
  parameter int CLK_PERIOD_NS       = 10,
  parameter int T_READ_CYCLE_NS     = 100,
  parameter int T_ADDR_ACCESS_NS    = 100,
  parameter int T_OE_ACCESS_NS      = 50,
  parameter int T_WRITE_CYCLE_NS    = 100,
  parameter int T_WRITE_PULSE_NS    = 75,
  parameter int T_ADDR_VALID_END_NS = 90,
  parameter int T_DATA_SETUP_NS     = 40,
  parameter int T_WE_FLOAT_NS       = 35
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              respValid,
  output logic [DATA_W-1:0] respRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  input  logic [DATA_W-1:0] memDin,
  output logic              memDriveEn,
  output logic              ramCeN,
  output logic              otpCeN,
  output logic              memWeN,
  output logic              memOeN
);

  localparam int RD_CYC = maxOf(ceilCycles(T_READ_CYCLE_NS, CLK_PERIOD_NS),
                           maxOf(ceilCycles(T_ADDR_ACCESS_NS, CLK_PERIOD_NS),
                                 ceilCycles(T_OE_ACCESS_NS, CLK_PERIOD_NS)));
  localparam int FLOAT_CYC = ceilCycles(T_WE_FLOAT_NS, CLK_PERIOD_NS);
  localparam int PULSE_CYC = maxOf(ceilCycles(T_WRITE_PULSE_NS, CLK_PERIOD_NS),
                              maxOf(ceilCycles(T_ADDR_VALID_END_NS, CLK_PERIOD_NS),
                                    FLOAT_CYC + ceilCycles(T_DATA_SETUP_NS, CLK_PERIOD_NS)));
  localparam int WC_CYC    = ceilCycles(T_WRITE_CYCLE_NS, CLK_PERIOD_NS);
  localparam int TAIL_CYC  = (WC_CYC > PULSE_CYC) ? WC_CYC - PULSE_CYC : 0;
  localparam int MAX_CYC   = maxOf(RD_CYC, maxOf(PULSE_CYC, TAIL_CYC));
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  strobe_t strobe;

  sram_cycle_ctrl_fsm #(
    .RD_CYC   (RD_CYC),
    .PULSE_CYC(PULSE_CYC),
    .FLOAT_CYC(FLOAT_CYC),
    .TAIL_CYC (TAIL_CYC),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strobe  (strobe)
  );

  sram_cycle_ctrl_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .memDin    (memDin),
    .respValid (respValid),
    .respRdata (respRdata),
    .memAddr   (memAddr),
    .memDout   (memDout),
    .memDriveEn(memDriveEn),
    .ramCeN    (ramCeN),
    .otpCeN    (otpCeN),
    .memWeN    (memWeN),
    .memOeN    (memOeN)
  );

endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
  parameter int ADDR_W              = 17,
  parameter int CLK_PERIOD_NS       = 10,
  parameter int T_READ_CYCLE_NS     = 100,
  parameter int T_ADDR_ACCESS_NS    = 100,
  parameter int T_OE_ACCESS_NS      = 50,
  parameter int T_WRITE_PULSE_NS    = 75,
  parameter int T_ADDR_VALID_END_NS = 90,
  parameter int T_DATA_SETUP_NS     = 40,
  parameter int T_WE_FLOAT_NS       = 35
) (
  input logic              clk,
  input logic              rst,
  input logic              reqReady,
  input logic              respValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memDriveEn,
  input logic              ramCeN,
  input logic              otpCeN,
  input logic              memWeN,
  input logic              memOeN
);

  int weRun;
  int oeRun;
  int drvRun;

  always_ff @(posedge clk) begin
    if (rst) begin
      weRun  <= 0;
      oeRun  <= 0;
      drvRun <= 0;
    end else begin
      weRun  <= !memWeN ? weRun + 1 : 0;
      oeRun  <= !memOeN ? oeRun + 1 : 0;
      drvRun <= memDriveEn ? drvRun + 1 : 0;
    end
  end

  p_otp_off_r8: assert property (@(posedge clk) disable iff (rst) otpCeN);

  p_we_oe_apart_r2: assert property (@(posedge clk) disable iff (rst)
    !(!memWeN && !memOeN));

  p_strobe_in_ce_r4: assert property (@(posedge clk) disable iff (rst)
    (!memWeN || !memOeN) |-> !ramCeN);

  p_drive_in_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    memDriveEn |-> !memWeN);

  p_no_drive_at_fall_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(memWeN) |-> !memDriveEn);

  p_float_wait_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(memDriveEn) |-> (weRun * CLK_PERIOD_NS >= T_WE_FLOAT_NS));

  p_setup_len_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(memWeN) |-> (drvRun * CLK_PERIOD_NS >= T_DATA_SETUP_NS));

  p_pulse_len_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(memWeN) |-> (weRun * CLK_PERIOD_NS >= T_WRITE_PULSE_NS) &&
                      (weRun * CLK_PERIOD_NS >= T_ADDR_VALID_END_NS));

  p_strobes_rise_together_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(memWeN) |-> ramCeN);

  p_read_len_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(memOeN) |-> (oeRun * CLK_PERIOD_NS >= T_READ_CYCLE_NS) &&
                      (oeRun * CLK_PERIOD_NS >= T_ADDR_ACCESS_NS) &&
                      (oeRun * CLK_PERIOD_NS >= T_OE_ACCESS_NS));

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!ramCeN && $past(!ramCeN)) |-> $stable(memAddr));

  p_resp_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    respValid |=> !respValid);

  p_busy_when_selected_r7: assert property (@(posedge clk) disable iff (rst)
    (!ramCeN || respValid) |-> !reqReady);

endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(
  .ADDR_W             (ADDR_W),
  .CLK_PERIOD_NS      (CLK_PERIOD_NS),
  .T_READ_CYCLE_NS    (T_READ_CYCLE_NS),
  .T_ADDR_ACCESS_NS   (T_ADDR_ACCESS_NS),
  .T_OE_ACCESS_NS     (T_OE_ACCESS_NS),
  .T_WRITE_PULSE_NS   (T_WRITE_PULSE_NS),
  .T_ADDR_VALID_END_NS(T_ADDR_VALID_END_NS),
  .T_DATA_SETUP_NS    (T_DATA_SETUP_NS),
  .T_WE_FLOAT_NS      (T_WE_FLOAT_NS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reqReady  (reqReady),
  .respValid (respValid),
  .memAddr   (memAddr),
  .memDriveEn(memDriveEn),
  .ramCeN    (ramCeN),
  .otpCeN    (otpCeN),
  .memWeN    (memWeN),
  .memOeN    (memOeN)
);

// File: tb/sram_cycle_ctrl_bench.sv
`timescale 1ns/1ps
module sram_cycle_ctrl_bench;

  localparam int AW = 17;
  localparam int DW = 8;

  function automatic int cdiv(input int ns, input int p);
    int c;
    c = (ns + p - 1) / p;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int P        = 10;
  localparam int EXP_RD   = mx(cdiv(100, P), mx(cdiv(100, P), cdiv(50, P)));
  localparam int EXP_FLT  = cdiv(35, P);
  localparam int EXP_WP   = mx(cdiv(75, P), mx(cdiv(90, P), EXP_FLT + cdiv(40, P)));
  localparam int EXP_WC   = cdiv(100, P);
  localparam int EXP_WBSY = mx(EXP_WP, EXP_WC) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic reqReady, respValid, memDriveEn, ramCeN, otpCeN, memWeN, memOeN;
  logic [DW-1:0] respRdata, memDout;
  logic [DW-1:0] memDin = '0;
  logic [AW-1:0] memAddr;

  always #5 clk = ~clk;

  sram_cycle_ctrl u_sram_cycle_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .respValid(respValid), .respRdata(respRdata), .memAddr(memAddr),
    .memDout(memDout), .memDin(memDin), .memDriveEn(memDriveEn),
    .ramCeN(ramCeN), .otpCeN(otpCeN), .memWeN(memWeN), .memOeN(memOeN)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [DW-1:0] busMem [int];
  logic [DW-1:0] expMem [int];

  int rdLow, weLow, drvCnt, drvStart, busyCnt, commits;
  bit addrFault, drvFault, otpFault, prevWeLow, prevDrive;
  logic [AW-1:0] opAddr, lastAddr;
  logic [DW-1:0] lastData;

  function automatic logic [DW-1:0] busRead(input logic [AW-1:0] a);
    return busMem.exists(int'(a)) ? busMem[int'(a)] : 8'h00;
  endfunction
  function automatic logic [DW-1:0] expRead(input logic [AW-1:0] a);
    return expMem.exists(int'(a)) ? expMem[int'(a)] : 8'h00;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // memory model and bus monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (otpCeN !== 1'b1) otpFault = 1;
      if (memDriveEn && memWeN) drvFault = 1;
      if (!ramCeN && memAddr !== opAddr) addrFault = 1;
      if (!reqReady) busyCnt++;
      if (!ramCeN && !memOeN) begin
        rdLow++;
        memDin = busRead(memAddr);
      end else begin
        memDin = 8'h00;
      end
      if (!memWeN) begin
        if (memDriveEn) begin
          if (drvCnt == 0) drvStart = weLow;
          drvCnt++;
          lastData = memDout;
          lastAddr = memAddr;
        end
        weLow++;
      end
      if (memWeN && prevWeLow && prevDrive) begin
        busMem[int'(lastAddr)] = lastData;
        commits++;
      end
      prevWeLow = !memWeN;
      prevDrive = memDriveEn;
    end
  end

  task automatic doOp(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input bit junk);
    int n;
    logic [DW-1:0] expD;
    @(negedge clk); #2;
    n = 0;
    while (!reqReady && n < 50) begin @(negedge clk); #2; n++; end
    expD = expRead(a);
    opAddr = a; rdLow = 0; weLow = 0; drvCnt = 0; drvStart = -1;
    busyCnt = 0; commits = 0; addrFault = 0; drvFault = 0;
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk); #2;
    check(reqReady == 1'b0, "R7 ready low after accept", reqReady, 0);
    if (junk) begin
      reqWrite = 1; reqAddr = a ^ 17'h0155; reqWdata = ~d;
    end else begin
      reqValid = 0;
    end
    n = 0;
    while (!respValid && n < 200) begin @(negedge clk); #2; n++; end
    reqValid = 0;
    check(respValid == 1'b1, "R7 response arrives", respValid, 1);
    check(!addrFault, "R2 address held", addrFault, 0);
    check(!drvFault, "R5 drive only in pulse", drvFault, 0);
    if (wr) begin
      check(weLow == EXP_WP, "R4 write pulse cycles", weLow, EXP_WP);
      check(rdLow == 0, "R4 no output enable in write", rdLow, 0);
      check(drvStart == EXP_FLT, "R5 float wait cycles", drvStart, EXP_FLT);
      check(drvCnt == EXP_WP - EXP_FLT, "R5 drive cycles", drvCnt, EXP_WP - EXP_FLT);
      check(commits == 1 && lastAddr == a, "R5 committed address", int'(lastAddr), int'(a));
      check(lastData == d, "R5 committed data", lastData, d);
      check(busyCnt == EXP_WBSY, "R6 write busy incl. tail", busyCnt, EXP_WBSY);
      expMem[int'(a)] = d;
    end else begin
      check(rdLow == EXP_RD, "R2 read cycles", rdLow, EXP_RD);
      check(weLow == 0, "R2 write enable high in read", weLow, 0);
      check(respRdata == expD, "R3 read data", respRdata, expD);
      check(busyCnt == EXP_RD + 1, "R7 read busy", busyCnt, EXP_RD + 1);
    end
    @(negedge clk); #2;
    check(respValid == 1'b0, "R7 single response cycle", respValid, 0);
    check(reqReady == 1'b1 && ramCeN == 1'b1, "R7 idle after response, held request ignored",
          {reqReady, ramCeN}, 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    opAddr = '0;
    repeat (3) @(negedge clk);
    #2;
    check(reqReady == 1 && respValid == 0, "R1 reset handshake", {reqReady, respValid}, 2);
    check(ramCeN == 1 && memWeN == 1 && memOeN == 1 && otpCeN == 1 && memDriveEn == 0,
          "R1 reset strobes", {ramCeN, memWeN, memOeN, otpCeN, memDriveEn}, 5'b11110);
    @(negedge clk); rst = 0;
    @(negedge clk); #2;
    check(reqReady == 1 && ramCeN == 1 && memDriveEn == 0, "R1 first cycle after reset",
          {reqReady, ramCeN, memDriveEn}, 3'b110);

    // directed corners
    doOp(0, 17'h00000, 8'h00, 0);
    doOp(1, 17'h00000, 8'hA5, 0);
    doOp(0, 17'h00000, 8'h00, 0);
    doOp(1, 17'h1FFFF, 8'hFF, 0);
    doOp(1, 17'h1FFFE, 8'h00, 0);
    doOp(0, 17'h1FFFF, 8'h00, 0);
    doOp(0, 17'h1FFFE, 8'h00, 0);
    doOp(1, 17'h00010, 8'h3C, 1);
    doOp(0, 17'h00010 ^ 17'h0155, 8'h00, 0);
    doOp(0, 17'h00010, 8'h00, 1);
    doOp(0, 17'h00010 ^ 17'h0155, 8'h00, 0);

    // constrained random
    for (int i = 0; i < 80; i++) begin
      logic [AW-1:0] a;
      bit wr, jk;
      a  = ($urandom_range(0, 3) == 0) ? AW'($urandom) : AW'($urandom_range(0, 15));
      wr = $urandom_range(0, 1) == 1;
      jk = $urandom_range(0, 4) == 0;
      doOp(wr, a, DW'($urandom), jk);
    end

    check(!otpFault, "R8 companion enable high", otpFault, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule